// File: doc/BRIEF.md
# Collision-Detect Distributed Bus Arbiter

This block lets several devices share a bus without a central arbiter. Each device has its own arbitration agent. When a device wants the bus, its agent waits for a cycle in which the shared lines show neither an arbitration round nor an owner. It then puts its identification code on a single shared open-drain line, one bit per cycle, starting with the most significant bit. It reads the line back in the same cycle. A driven 1 overrides a 0. So an agent that sent a 0 but reads back a 1 has collided. It withdraws at once and waits a random number of idle slots before it tries again. The window for that wait doubles with every consecutive loss, up to a cap.

An agent that gets through every code bit without a mismatch has won. It raises its grant and holds the shared busy line until its request drops. The device code is the agent's index, so the highest-numbered device among those that start a round together wins it. The top module connects N agents and forms the wired-OR of their arbitration, round-activity and busy drives. The data transfer that follows a grant is not part of this block.

Top module: `cda_cluster`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all grant bits and the busy output are 0.
- R2: A single device that raises its request while the bus is idle sees its grant ID_W+1 clock edges later. ID_W is clog2(N_DEV). The grant is 0 one edge earlier.
- R3: The code of device i is i, driven most significant bit first, and a 1 on the shared line dominates. When several devices start a round in the same cycle, the highest index among them is granted, with the R2 latency.
- R4: At most one grant bit is 1 in any cycle.
- R5: A grant stays 1 while its request stays 1. It returns to 0 on the first edge that samples the request low. The busy output equals the OR of all grant bits.
- R6: A round starts only in a cycle where no round is running and no device holds the bus. A lone request raised while another device owns the bus waits. It is granted ID_W+2 edges after the owner drops its request.
- R7: A device that loses a round backs off. After k consecutive losses it skips a pseudo-random number of idle slots in the range 0 to 2^min(k,BO_CAP)-1 before it rejoins. With no other contender it is therefore granted within 2^BO_CAP+ID_W+1 edges after the owner releases.
- R8: A device that drops its request during a round leaves the round without a grant and stops marking the round active. A later lone request is then granted with the R2 latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_i | input | N_DEV | Per-device bus request |
| grant_o | output | N_DEV | Per-device bus grant |
| busy_o | output | 1 | Wired-OR busy (release) line; 1 while any device owns the bus |

## Verification
The bench builds the cluster with N_DEV=4 (a two-bit code), BO_CAP=3 and an 8-bit back-off generator. With these values, both code bits decide real collisions: device 2 beats device 1 on the first bit, and device 3 beats device 2 on the second. Back-off windows reach 7 slots, so repeated losses among four contenders become reachable within a short run. A per-clock reference model checks one-hot grant, busy tracking and grant hold/release on every cycle. Directed cases pin the exact grant latencies and the winner.

// File: rtl/cda_pkg.sv
package cda_pkg;

  typedef enum logic [1:0] {
    AG_IDLE    = 2'd0,
    AG_ARB     = 2'd1,
    AG_BACKOFF = 2'd2,
    AG_OWN     = 2'd3
  } ag_state_e;

endpackage

// File: rtl/cda_lfsr.sv
module cda_lfsr #(
  parameter int unsigned         WIDTH = 8,
  parameter logic [WIDTH-1:0]    TAPS  = 8'hB8,
  parameter logic [WIDTH-1:0]    SEED  = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [WIDTH-1:0] value_o
);

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;

  // Galois form: shift right, fold taps in when the outgoing bit is 1
  always_comb begin
    state_d = {1'b0, state_q[WIDTH-1:1]};
    if (state_q[0]) state_d = state_d ^ TAPS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign value_o = state_q;

endmodule

// File: rtl/cda_backoff.sv
module cda_backoff #(
  parameter int unsigned BO_CAP = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,   // round just lost
  input  logic              clear_i,  // won or gave up: reset loss history
  input  logic              tick_i,   // one idle slot observed while waiting
  input  logic [BO_CAP-1:0] rnd_i,
  output logic              expired_o
);

  localparam int unsigned LOSS_W = $clog2(BO_CAP + 1);
  localparam logic [LOSS_W-1:0] LOSS_MAX = LOSS_W'(BO_CAP);

  logic [LOSS_W-1:0] loss_q, loss_d, loss_inc;
  logic [BO_CAP-1:0] cnt_q, cnt_d, win_mask;
  logic              loss_en, cnt_en;

  assign loss_inc = (loss_q == LOSS_MAX) ? loss_q : loss_q + 1'b1;

  // window mask holds loss_inc low-order ones
  generate
    for (genvar b = 0; b < BO_CAP; b++) begin : g_mask
      assign win_mask[b] = (LOSS_W'(b) < loss_inc);
    end
  endgenerate

  always_comb begin
    loss_en = load_i | clear_i;
    loss_d  = clear_i ? '0 : loss_inc;
    cnt_en  = load_i | (tick_i & (cnt_q != '0));
    cnt_d   = load_i ? (rnd_i & win_mask) : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       loss_q <= '0;
    else if (loss_en) loss_q <= loss_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

  // R7: a pending count only moves on an idle slot or a fresh load
  a_r7_count_waits_for_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cnt_q));

endmodule

// File: rtl/cda_agent.sv
module cda_agent
  import cda_pkg::*;
#(
  parameter int unsigned      DEV_ID = 0,
  parameter int unsigned      ID_W   = 2,
  parameter int unsigned      LFSR_W = 8,
  parameter logic [LFSR_W-1:0] TAPS  = 8'hB8,
  parameter int unsigned      BO_CAP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic arb_rd_i,    // shared code line, read back
  input  logic act_rd_i,    // shared round-active line
  input  logic busy_rd_i,   // shared busy line
  output logic arb_drv_o,
  output logic act_drv_o,
  output logic busy_drv_o,
  output logic grant_o
);

  localparam int unsigned IDX_W   = (ID_W > 1) ? $clog2(ID_W) : 1;
  localparam int unsigned IDX_TOP = ID_W - 1;
  localparam logic [ID_W-1:0]  CODE = ID_W'(DEV_ID);
  localparam int unsigned SEED_I  = (DEV_ID * 29 + 71) % (2 ** LFSR_W);
  localparam logic [LFSR_W-1:0] SEED = (SEED_I == 0) ? LFSR_W'(1) : LFSR_W'(SEED_I);

  ag_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic             my_bit, idle_slot, lost;
  logic             bo_load, bo_clear, bo_tick, bo_expired;
  logic [LFSR_W-1:0] rnd;

  cda_lfsr #(.WIDTH(LFSR_W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .value_o(rnd)
  );

  cda_backoff #(.BO_CAP(BO_CAP)) u_bo (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (bo_load),
    .clear_i  (bo_clear),
    .tick_i   (bo_tick),
    .rnd_i    (rnd[BO_CAP-1:0]),
    .expired_o(bo_expired)
  );

  assign my_bit    = CODE[idx_q];
  assign idle_slot = ~act_rd_i & ~busy_rd_i;
  assign lost      = (state_q == AG_ARB) & ~my_bit & arb_rd_i;

  always_comb begin
    state_d  = state_q;
    idx_en   = 1'b0;
    idx_d    = idx_q - 1'b1;
    bo_load  = 1'b0;
    bo_clear = 1'b0;
    bo_tick  = 1'b0;
    unique case (state_q)
      AG_IDLE: begin
        if (req_i && idle_slot) begin
          state_d = AG_ARB;
          idx_en  = 1'b1;
          idx_d   = IDX_TOP[IDX_W-1:0];
        end
      end
      AG_ARB: begin
        if (!req_i) begin
          state_d  = AG_IDLE;
          bo_clear = 1'b1;
        end else if (lost) begin
          state_d = AG_BACKOFF;
          bo_load = 1'b1;
        end else if (idx_q == '0) begin
          state_d  = AG_OWN;
          bo_clear = 1'b1;
        end else begin
          idx_en = 1'b1;
        end
      end
      AG_BACKOFF: begin
        if (!req_i) begin
          state_d  = AG_IDLE;
          bo_clear = 1'b1;
        end else if (idle_slot) begin
          bo_tick = 1'b1;
          if (bo_expired) begin
            state_d = AG_ARB;
            idx_en  = 1'b1;
            idx_d   = IDX_TOP[IDX_W-1:0];
          end
        end
      end
      AG_OWN: begin
        if (!req_i) state_d = AG_IDLE;
      end
      default: state_d = AG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= AG_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign act_drv_o  = (state_q == AG_ARB);
  assign arb_drv_o  = act_drv_o & my_bit;
  assign busy_drv_o = (state_q == AG_OWN);
  assign grant_o    = busy_drv_o;

  // R2: a grant is only ever reached through an arbitration round
  a_r2_grant_after_round: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_o) |-> $past(act_drv_o));

  // R6: joining a round requires an idle bus in the previous cycle
  a_r6_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_drv_o) |-> $past(idle_slot));

  // R8: a withdrawn request leaves the round on the next edge
  a_r8_drop_leaves_round: assert property (@(posedge clk) disable iff (!rst_n)
    (act_drv_o && !req_i) |=> (!act_drv_o && !grant_o));

endmodule

// File: rtl/cda_cluster.sv
module cda_cluster #(
  parameter int unsigned N_DEV  = 4,
  parameter int unsigned LFSR_W = 8,
  parameter int unsigned BO_CAP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DEV-1:0] req_i,
  output logic [N_DEV-1:0] grant_o,
  output logic             busy_o
);

  localparam int unsigned ID_W = $clog2(N_DEV);

  logic [N_DEV-1:0] arb_drv, act_drv, busy_drv;
  logic             arb_line, act_line, busy_line;

  // open-drain lines modelled as OR of the drives
  assign arb_line  = |arb_drv;
  assign act_line  = |act_drv;
  assign busy_line = |busy_drv;

  generate
    for (genvar d = 0; d < N_DEV; d++) begin : g_dev
      cda_agent #(
        .DEV_ID(d),
        .ID_W  (ID_W),
        .LFSR_W(LFSR_W),
        .TAPS  (LFSR_W'(8'hB8)),
        .BO_CAP(BO_CAP)
      ) u_agent (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i[d]),
        .arb_rd_i  (arb_line),
        .act_rd_i  (act_line),
        .busy_rd_i (busy_line),
        .arb_drv_o (arb_drv[d]),
        .act_drv_o (act_drv[d]),
        .busy_drv_o(busy_drv[d]),
        .grant_o   (grant_o[d])
      );

      // R5: an owner keeps the bus while it still requests
      a_r5_hold_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o[d] && req_i[d]) |=> grant_o[d]);
    end
  endgenerate

  assign busy_o = busy_line;

  // R4: mutual exclusion across the distributed agents
  a_r4_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R3: after any round, the owner is alone on the bus
  a_r3_round_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_line) |-> ($countones(grant_o) <= 1));

endmodule

// File: tb/cda_cluster_test.sv
module cda_cluster_test;

  localparam int N    = 4;
  localparam int IDW  = 2;
  localparam int CAP  = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req;
  logic [N-1:0] grant;
  logic         busy;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit mon_en = 1'b0;
  bit done   = 1'b0;

  cda_cluster #(.N_DEV(N), .LFSR_W(8), .BO_CAP(CAP)) uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req),
    .grant_o(grant),
    .busy_o (busy)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive just after a falling edge, so sampling at the falling edge sees settled values
  task automatic drive(input logic [N-1:0] r);
    @(negedge clk);
    #1 req = r;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // reference model, compared every clock at the falling edge
  logic [N-1:0] prev_g = '0;
  always @(negedge clk) begin
    if (mon_en) begin
      chk($onehot0(grant), "R4 one grant", grant, 0);
      chk(busy == |grant, "R5 busy follows grant", busy, |grant);
      for (int i = 0; i < N; i++) begin
        if (prev_g[i] && req[i]) chk(grant[i], "R5 hold", grant, prev_g);
        if (!req[i])             chk(!grant[i], "R5 release", grant, 0);
        if (grant[i] && !prev_g[i]) chk(req[i], "R5 grant needs request", req, grant);
      end
      prev_g = grant;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog R4 actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int wait_n;
    int served;
    logic [N-1:0] want;
    rst_n = 1'b0;
    req   = '0;
    repeat (3) @(negedge clk);
    chk(grant == 0 && busy == 0, "R1 reset", {busy, grant}, 0);
    rst_n = 1'b1;
    edges(1);
    chk(grant == 0 && busy == 0, "R1 after reset", {busy, grant}, 0);
    mon_en = 1'b1;

    // R2: lone requester latency
    drive(4'b0010);
    edges(IDW);
    chk(grant == 0, "R2 not yet", grant, 0);
    edges(1);
    chk(grant == 4'b0010, "R2 lone grant", grant, 4'b0010);
    chk(busy, "R5 busy high", busy, 1);
    drive(4'b0000);
    edges(1);
    chk(grant == 0 && !busy, "R5 drop", {busy, grant}, 0);

    // R3: devices 1 and 2 collide, 2 wins
    drive(4'b0110);
    edges(IDW + 1);
    chk(grant == 4'b0100, "R3 two contenders", grant, 4'b0100);
    // R7: loser granted within back-off bound once the owner leaves
    drive(4'b0010);
    wait_n = 0;
    while (grant != 4'b0010 && wait_n < (1 << CAP) + IDW + 1) begin
      edges(1);
      wait_n++;
    end
    chk(grant == 4'b0010, "R7 loser served in bound", wait_n, (1 << CAP) + IDW + 1);
    drive(4'b0000);
    edges(2);

    // R3: three contenders, highest code wins
    drive(4'b1101);
    edges(IDW + 1);
    chk(grant == 4'b1000, "R3 three contenders", grant, 4'b1000);
    drive(4'b0000);
    edges(12);

    // R6: a request during ownership waits for release
    drive(4'b0001);
    edges(IDW + 1);
    chk(grant == 4'b0001, "R6 owner", grant, 4'b0001);
    drive(4'b1001);
    edges(5);
    chk(grant == 4'b0001, "R6 no preemption", grant, 4'b0001);
    drive(4'b1000);
    edges(IDW + 1);
    chk(grant == 0, "R6 not before slot", grant, 0);
    edges(1);
    chk(grant == 4'b1000, "R6 grant after release", grant, 4'b1000);
    drive(4'b0000);
    edges(2);

    // R8: withdraw mid-round
    drive(4'b0100);
    edges(1);
    drive(4'b0000);
    edges(1);
    chk(grant == 0 && !busy, "R8 no grant after withdraw", {busy, grant}, 0);
    drive(4'b0010);
    edges(IDW + 1);
    chk(grant == 4'b0010, "R8 later lone grant", grant, 4'b0010);
    drive(4'b0000);
    edges(2);

    // R4/R7 stress: everyone contends, each owner holds a few cycles
    want = 4'b1111;
    served = 0;
    drive(want);
    edges(IDW + 1);
    chk(grant == 4'b1000, "R3 four contenders", grant, 4'b1000);
    wait_n = 0;
    while (want != 0 && wait_n < 600) begin
      if (grant != 0) begin
        edges(3);
        want = want & ~grant;
        served++;
        drive(want);
      end
      edges(1);
      wait_n++;
    end
    chk(want == 0 && served == N, "R7 all contenders served", served, N);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule